// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out the single-bit instructions of a small controller. The carry flag serves as a one-bit accumulator. Each request names an operation and an absolute 8-bit bit address. The request also carries the current value of the addressed bit, read from storage outside the block, and the current carry. One clock later the block returns three results: a write strobe with the new value for the addressed bit, a write strobe with the new value for carry, and a branch-taken flag for the three test-and-jump operations. Mapping the bit address to a byte and a bit position is done elsewhere, and so is the storage itself.

Carry is also bit 7 of the status word, which sits at one fixed bit address. An operation aimed at that address reads carry as its operand. Any result that would go to the addressed bit is written through the carry strobe instead. No indirect or indexed form of addressing exists. The address always arrives whole with the request.

Top module: `bitproc_top`

## Requirements
- R1: While `rst_n` is low, and once it has been released, every output is 0 until a request is accepted. Asserting `rst_n` clears the outputs at once, without waiting for a clock edge.
- R2: A request presented with `op_valid` high produces its results one clock edge later. After an edge with `op_valid` low, all strobes, both write values and `jump_taken` are 0. Whenever a write strobe is low, its value output is 0.
- R3: Codes 1 (set), 2 (clear) and 3 (complement) raise `bit_wr_en` with the value 1, 0 or the inverse of `bit_rd` respectively. `carry_wr_en` stays low.
- R4: Codes 4 (set carry), 5 (clear carry) and 6 (complement carry) raise `carry_wr_en` with the value 1, 0 or the inverse of `carry_rd`. `bit_wr_en` stays low, and `bit_rd` and `bit_addr` have no effect on the outputs.
- R5: Code 7 (jump if set) raises `jump_taken` when the operand is 1. Code 8 (jump if clear) raises it when the operand is 0. Neither code raises a write strobe.
- R6: When the operand is 1, code 9 (jump if set, then clear) raises `jump_taken` and writes 0 to the operand in the same result. When the operand is 0 it writes nothing and does not jump.
- R7: Code 10 copies the operand into carry through `carry_wr_en`. Code 11 copies `carry_rd` into the addressed bit through `bit_wr_en`.
- R8: Codes 12 (OR), 13 (OR with inverted operand), 14 (AND) and 15 (AND with inverted operand) write the combined value of carry and the operand to carry. `bit_wr_en` stays low.
- R9: When `bit_addr` equals `CARRY_ADDR` (default 0xD7), the operand is `carry_rd` and `bit_rd` is ignored. A result bound for the addressed bit goes out on `carry_wr_en` and `carry_wr_val`, and `bit_wr_en` stays low.
- R10: Code 0 is a no-operation. It produces no strobe and no jump. At most one of the two write strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| bit_addr | input | ADDR_W | Absolute bit address |
| bit_rd | input | 1 | Current value of the addressed bit |
| carry_rd | input | 1 | Current carry flag |
| bit_wr_en | output | 1 | Write strobe for the addressed bit |
| bit_wr_val | output | 1 | New value for the addressed bit |
| carry_wr_en | output | 1 | Write strobe for carry |
| carry_wr_val | output | 1 | New value for carry |
| jump_taken | output | 1 | Branch condition of a test-and-jump is met |

## Verification
Two functions can act in the same cycle. The test-and-clear jump raises `jump_taken` and a write of 0 together. The carry alias turns a bit-directed write into a carry write. The bench drives every operation code against all 256 addresses and all four combinations of `bit_rd` and `carry_rd`. This provokes both overlaps, including the test-and-clear jump at the carry address. Each result is compared as a whole against a model in the bench, so a jump without its clear, or a clear sent to the wrong strobe, counts as a miscompare.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_SETB  = 4'h1,
    OP_CLRB  = 4'h2,
    OP_CPLB  = 4'h3,
    OP_SETC  = 4'h4,
    OP_CLRC  = 4'h5,
    OP_CPLC  = 4'h6,
    OP_JSET  = 4'h7,
    OP_JCLR  = 4'h8,
    OP_JSC   = 4'h9,
    OP_LDC   = 4'hA,
    OP_STC   = 4'hB,
    OP_ORC   = 4'hC,
    OP_ORNC  = 4'hD,
    OP_ANDC  = 4'hE,
    OP_ANDNC = 4'hF
  } bp_op_e;

  typedef enum logic [2:0] {
    FN_ONE, FN_ZERO, FN_NOT_SRC, FN_NOT_C, FN_SRC, FN_C, FN_OR, FN_AND
  } bp_fn_e;

  typedef struct packed {
    logic   wr_bit;
    logic   wr_carry;
    logic   wr_cond;
    logic   jmp;
    logic   jmp_on_set;
    logic   inv_src;
    bp_fn_e fn;
  } bp_ctrl_t;

  typedef struct packed {
    logic bit_we;
    logic bit_val;
    logic c_we;
    logic c_val;
    logic jump;
  } bp_res_t;

endpackage

// File: rtl/bitproc_rst_sync.sv
module bitproc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bitproc_decode.sv
module bitproc_decode
  import bitproc_pkg::*;
(
  input  logic [3:0] op_code,
  output bp_ctrl_t   ctrl
);
  always_comb begin
    ctrl = '{wr_bit: 1'b0, wr_carry: 1'b0, wr_cond: 1'b0, jmp: 1'b0,
             jmp_on_set: 1'b0, inv_src: 1'b0, fn: FN_ZERO};
    unique case (bp_op_e'(op_code))
      OP_NOP:   ;
      OP_SETB:  begin ctrl.wr_bit = 1'b1;   ctrl.fn = FN_ONE;     end
      OP_CLRB:  begin ctrl.wr_bit = 1'b1;   ctrl.fn = FN_ZERO;    end
      OP_CPLB:  begin ctrl.wr_bit = 1'b1;   ctrl.fn = FN_NOT_SRC; end
      OP_SETC:  begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_ONE;     end
      OP_CLRC:  begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_ZERO;    end
      OP_CPLC:  begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_NOT_C;   end
      OP_JSET:  begin ctrl.jmp = 1'b1; ctrl.jmp_on_set = 1'b1;    end
      OP_JCLR:  begin ctrl.jmp = 1'b1; ctrl.jmp_on_set = 1'b0;    end
      OP_JSC: begin
        ctrl.jmp = 1'b1; ctrl.jmp_on_set = 1'b1;
        ctrl.wr_bit = 1'b1; ctrl.wr_cond = 1'b1; ctrl.fn = FN_ZERO;
      end
      OP_LDC:   begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_SRC;     end
      OP_STC:   begin ctrl.wr_bit = 1'b1;   ctrl.fn = FN_C;       end
      OP_ORC:   begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_OR;      end
      OP_ORNC:  begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_OR;  ctrl.inv_src = 1'b1; end
      OP_ANDC:  begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_AND;     end
      OP_ANDNC: begin ctrl.wr_carry = 1'b1; ctrl.fn = FN_AND; ctrl.inv_src = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/bitproc_datapath.sv
module bitproc_datapath
  import bitproc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  bp_ctrl_t          ctrl,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_rd,
  input  logic              carry_rd,
  output bp_res_t           res
);
  logic is_alias;
  logic src;
  logic src_eff;
  logic value;
  logic bit_go;

  always_comb begin
    is_alias = (bit_addr == CARRY_ADDR);
    src      = is_alias ? carry_rd : bit_rd;
    src_eff  = ctrl.inv_src ? ~src : src;

    unique case (ctrl.fn)
      FN_ONE:     value = 1'b1;
      FN_ZERO:    value = 1'b0;
      FN_NOT_SRC: value = ~src;
      FN_NOT_C:   value = ~carry_rd;
      FN_SRC:     value = src;
      FN_C:       value = carry_rd;
      FN_OR:      value = carry_rd | src_eff;
      FN_AND:     value = carry_rd & src_eff;
      default:    value = 1'b0;
    endcase

    bit_go = ctrl.wr_bit & (~ctrl.wr_cond | src);

    res.jump    = ctrl.jmp & (ctrl.jmp_on_set ? src : ~src);
    res.bit_we  = bit_go & ~is_alias;
    res.c_we    = ctrl.wr_carry | (bit_go & is_alias);
    res.bit_val = res.bit_we & value;
    res.c_val   = res.c_we & value;
  end
endmodule

// File: rtl/bitproc_top.sv
module bitproc_top
  import bitproc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CARRY_ADDR = 8'hD7,
  parameter int                RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_rd,
  input  logic              carry_rd,
  output logic              bit_wr_en,
  output logic              bit_wr_val,
  output logic              carry_wr_en,
  output logic              carry_wr_val,
  output logic              jump_taken
);
  logic     rst_sync_n;
  bp_ctrl_t ctrl;
  bp_res_t  res_comb;
  bp_res_t  res_d;
  bp_res_t  res_q;

  bitproc_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitproc_decode decode_i (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  bitproc_datapath #(.ADDR_W(ADDR_W), .CARRY_ADDR(CARRY_ADDR)) datapath_i (
    .ctrl     (ctrl),
    .bit_addr (bit_addr),
    .bit_rd   (bit_rd),
    .carry_rd (carry_rd),
    .res      (res_comb)
  );

  // next-state
  always_comb begin
    if (op_valid) res_d = res_comb;
    else          res_d = '0;
  end

  // register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) res_q <= '0;
    else             res_q <= res_d;
  end

  assign bit_wr_en    = res_q.bit_we;
  assign bit_wr_val   = res_q.bit_val;
  assign carry_wr_en  = res_q.c_we;
  assign carry_wr_val = res_q.c_val;
  assign jump_taken   = res_q.jump;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> !bit_wr_en && !carry_wr_en && !jump_taken); // R2
  AST_CARRY_OP_NO_BIT_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code inside {OP_SETC, OP_CLRC, OP_CPLC}) |=> carry_wr_en && !bit_wr_en); // R4
  AST_TEST_JUMP_NO_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code inside {OP_JSET, OP_JCLR}) |=> !bit_wr_en && !carry_wr_en); // R5
  AST_JSC_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && op_code == OP_JSC && bit_addr != CARRY_ADDR && bit_rd
    |=> jump_taken && bit_wr_en && !bit_wr_val); // R6
  AST_JSC_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && op_code == OP_JSC && bit_addr != CARRY_ADDR && !bit_rd
    |=> !jump_taken && !bit_wr_en && !carry_wr_en); // R6
  AST_ALIAS_NO_BIT_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && bit_addr == CARRY_ADDR |=> !bit_wr_en); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({bit_wr_en, carry_wr_en})); // R10
endmodule

// File: tb/bitproc_top_tb_top.sv
`timescale 1ns/1ps
module bitproc_top_tb_top;
  localparam logic [7:0] CADDR = 8'hD7;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] bit_addr;
  logic       bit_rd;
  logic       carry_rd;
  logic       bit_wr_en, bit_wr_val, carry_wr_en, carry_wr_val, jump_taken;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  bitproc_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .bit_addr     (bit_addr),
    .bit_rd       (bit_rd),
    .carry_rd     (carry_rd),
    .bit_wr_en    (bit_wr_en),
    .bit_wr_val   (bit_wr_val),
    .carry_wr_en  (carry_wr_en),
    .carry_wr_val (carry_wr_val),
    .jump_taken   (jump_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected {bit_we, bit_val, c_we, c_val, jump}
  function automatic logic [4:0] model(input logic [3:0] op, input logic [7:0] a,
                                       input logic b, input logic c);
    logic s, to_bit, to_c, v, j;
    s = (a == CADDR) ? c : b;
    to_bit = 0; to_c = 0; v = 0; j = 0;
    case (op)
      4'h1: begin to_bit = 1; v = 1;  end
      4'h2: begin to_bit = 1; v = 0;  end
      4'h3: begin to_bit = 1; v = !s; end
      4'h4: begin to_c = 1; v = 1;  end
      4'h5: begin to_c = 1; v = 0;  end
      4'h6: begin to_c = 1; v = !c; end
      4'h7: j = s;
      4'h8: j = !s;
      4'h9: begin j = s; to_bit = s; v = 0; end
      4'hA: begin to_c = 1; v = s; end
      4'hB: begin to_bit = 1; v = c; end
      4'hC: begin to_c = 1; v = c | s;  end
      4'hD: begin to_c = 1; v = c | !s; end
      4'hE: begin to_c = 1; v = c & s;  end
      4'hF: begin to_c = 1; v = c & !s; end
      default: ;
    endcase
    if (a == CADDR && to_bit) begin to_c = 1; to_bit = 0; end
    return {to_bit, to_bit & v, to_c, to_c & v, j};
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic [7:0] a);
    if (a == CADDR) return "R9";
    case (op)
      4'h0: return "R10";
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6: return "R4";
      4'h7, 4'h8: return "R5";
      4'h9: return "R6";
      4'hA, 4'hB: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {bit_wr_en, bit_wr_val, carry_wr_en, carry_wr_val, jump_taken};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s op=%h addr=%h bit=%b c=%b actual=%b expected=%b",
               req, op_code, bit_addr, bit_rd, carry_rd, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; bit_addr = 0; bit_rd = 0; carry_rd = 0;
    repeat (3) @(negedge clk);
    check("R1", 5'b0);                   // held in reset
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", 5'b0);                   // released, no request yet

    // R2: idle requests produce nothing
    for (int op = 0; op < 16; op++) begin
      op_valid = 0; op_code = 4'(op); bit_addr = 8'(op * 17); bit_rd = 1; carry_rd = 1;
      @(negedge clk);
      check("R2", 5'b0);
    end

    // exhaustive sweep: every code, address, operand and carry
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bc = 0; bc < 4; bc++) begin
          op_valid = 1; op_code = 4'(op); bit_addr = 8'(a);
          bit_rd = bc[0]; carry_rd = bc[1];
          @(negedge clk);
          check(req_of(op_code, bit_addr), model(op_code, bit_addr, bit_rd, carry_rd));
        end
      end
    end

    // R2: valid dropped after an active result clears outputs next edge
    op_valid = 1; op_code = 4'h9; bit_addr = 8'h20; bit_rd = 1; carry_rd = 0;
    @(negedge clk);
    check("R6", 5'b10001);
    op_valid = 0;
    @(negedge clk);
    check("R2", 5'b0);

    // R1: asynchronous clear mid-operation
    op_valid = 1; op_code = 4'h1; bit_addr = 8'h05;
    @(negedge clk);
    check("R3", 5'b11000);
    rst_n = 0;
    #1;
    check("R1", 5'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", 5'b0);
    op_valid = 0;
    repeat (3) @(negedge clk);
    report();
  end
endmodule